// File: doc/BRIEF.md
# UART Interrupt Request Aggregator with Address Qualification

This block combines the status events of a UART transmitter and receiver into one interrupt request. It keeps four status flags that software can read but cannot write: transmit buffer empty, transmitter idle, receive data ready and receive overrun. Each flag is set by a pulse from the UART datapath. Each flag clears only on its own UART action: a data read, a status read followed by a data read, a transmit-register write, or the start of a transmission. Taking the interrupt does not clear any flag.

Each flag passes through its own enable. A wake edge on the receive pin joins them through a wake enable. The enabled sources are then ORed together. A rising edge of that OR sets a sticky request flag, which the interrupt controller clears with an acknowledge pulse. The request reaches the CPU only while both the module enable and the global enable are high.

When address qualification is on, receive-ready counts as a source only if the top bit of the stored word is 1. That top bit is bit 8 in 9-bit mode and bit 7 in 8-bit mode. Such a word is treated as an address. While address qualification is on, the parity enable passed on to the receiver is forced to 0.

Top module: `uart_irq_agg`

## Requirements
- R1: After reset, tx_empty_o and tx_idle_o are 1, and rx_ready_o, overrun_o and irq_flag_o are 0.
- R2: A pulse on rx_done_i stores rx_word_i in rx_data_o and sets rx_ready_o on the next cycle. A pulse on data_rd_i clears rx_ready_o. When both pulses arrive in the same cycle, the set wins.
- R3: A pulse on overrun_i sets overrun_o. overrun_o clears only on a data_rd_i pulse that follows a stat_rd_i pulse seen while overrun_o was 1. A data read with no such status read leaves overrun_o at 1.
- R4: tx_wr_i clears tx_empty_o, and tx_start_i clears tx_idle_o. tx_empty_set_i and tx_idle_set_i set them again, and a set wins over a clear in the same cycle.
- R5: Each source reaches the request only through its own enable: rx_ready_o or overrun_o through rx_ie_i, tx_idle_o through idle_ie_i, tx_empty_o through empty_ie_i, and wake_edge_i through wake_en_i. A source whose enable is 0 never sets irq_flag_o.
- R6: With addr_det_i at 0, any stored word raises a request. With addr_det_i at 1, a stored word raises a request only if its top bit is 1, where the top bit is bit 8 when nine_bit_i is 1 and bit 7 when nine_bit_i is 0.
- R7: irq_flag_o is set one cycle after the combined enabled source rises. It stays set until an ack_i pulse. If a set and ack_i arrive in the same cycle, the flag stays set.
- R8: irq_o is 1 only when irq_flag_o, mod_ie_i and glob_ie_i are all 1.
- R9: parity_en_eff_o follows parity_en_i when addr_det_i is 0, and is 0 when addr_det_i is 1.
- R10: ack_i clears irq_flag_o only. It leaves every status flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_empty_set_i | input | 1 | Transmit buffer became empty (pulse) |
| tx_wr_i | input | 1 | Transmit data register written (pulse) |
| tx_idle_set_i | input | 1 | Transmitter went idle (pulse) |
| tx_start_i | input | 1 | New transmission started (pulse) |
| rx_done_i | input | 1 | Word received (pulse) |
| rx_word_i | input | WORD_W | Received word |
| overrun_i | input | 1 | Receiver overrun (pulse) |
| stat_rd_i | input | 1 | Status register read (pulse) |
| data_rd_i | input | 1 | Receive data register read (pulse) |
| wake_edge_i | input | 1 | Edge on RX pin during sleep (pulse) |
| nine_bit_i | input | 1 | 1 selects 9-bit words, 0 selects 8-bit words |
| rx_ie_i | input | 1 | Receive/overrun interrupt enable |
| idle_ie_i | input | 1 | Transmitter idle interrupt enable |
| empty_ie_i | input | 1 | Transmit empty interrupt enable |
| wake_en_i | input | 1 | Wake source enable |
| addr_det_i | input | 1 | Address qualification enable |
| parity_en_i | input | 1 | Requested parity enable |
| mod_ie_i | input | 1 | Module interrupt enable |
| glob_ie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Request acknowledge (pulse) |
| tx_empty_o | output | 1 | Transmit empty flag |
| tx_idle_o | output | 1 | Transmitter idle flag |
| rx_ready_o | output | 1 | Receive data ready flag |
| overrun_o | output | 1 | Overrun flag |
| rx_data_o | output | WORD_W | Stored received word |
| parity_en_eff_o | output | 1 | Parity enable passed to the receiver |
| irq_flag_o | output | 1 | Sticky request flag |
| irq_o | output | 1 | Request to the CPU |

## Verification
Two events can land in the same cycle: a request set, caused by a source edge, and the acknowledge that the controller uses to clear it. The bench stores a word so that the rising edge of the source falls exactly on the clock edge where ack_i is pulsed. It then expects irq_flag_o to remain 1, and to drop to 0 only on a second, lone acknowledge. Two further collisions are driven in the same way: a flag's set pulse together with its clearing action, where the flag is expected to stay at 1, and an acknowledge while rx_ready_o is held, where the status flag is expected to stay at 1.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef struct packed {
    logic tx_empty;
    logic tx_idle;
    logic rx_ready;
    logic overrun;
  } uart_stat_t;
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_empty_set_i,
  input  logic              tx_wr_i,
  input  logic              tx_idle_set_i,
  input  logic              tx_start_i,
  input  logic              rx_done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              overrun_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  output uart_stat_t        stat_o,
  output logic [WORD_W-1:0] rx_data_o
);
  uart_stat_t        stat_q;
  logic [WORD_W-1:0] word_q;
  logic              ovr_armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q      <= '{tx_empty: 1'b1, tx_idle: 1'b1, rx_ready: 1'b0, overrun: 1'b0};
      word_q      <= '0;
      ovr_armed_q <= 1'b0;
    end else begin
      // set events win over clearing actions
      if (tx_empty_set_i)  stat_q.tx_empty <= 1'b1;
      else if (tx_wr_i)    stat_q.tx_empty <= 1'b0;
      if (tx_idle_set_i)   stat_q.tx_idle  <= 1'b1;
      else if (tx_start_i) stat_q.tx_idle  <= 1'b0;
      if (rx_done_i)       stat_q.rx_ready <= 1'b1;
      else if (data_rd_i)  stat_q.rx_ready <= 1'b0;
      if (rx_done_i)       word_q          <= rx_word_i;
      if (overrun_i)                      stat_q.overrun <= 1'b1;
      else if (data_rd_i && ovr_armed_q)  stat_q.overrun <= 1'b0;
      // status read while overrun arms the clear by the next data read
      if (data_rd_i)                            ovr_armed_q <= 1'b0;
      else if (stat_rd_i && stat_q.overrun)     ovr_armed_q <= 1'b1;
    end
  end

  assign stat_o    = stat_q;
  assign rx_data_o = word_q;
endmodule

// File: rtl/uart_irq_qual.sv
module uart_irq_qual
  import uart_irq_pkg::*;
(
  input  uart_stat_t stat_i,
  input  logic [1:0] rx_top_i,
  input  logic       nine_bit_i,
  input  logic       addr_det_i,
  input  logic       parity_en_i,
  input  logic       rx_ie_i,
  input  logic       idle_ie_i,
  input  logic       empty_ie_i,
  input  logic       wake_en_i,
  input  logic       wake_edge_i,
  output logic       src_o,
  output logic       parity_en_eff_o
);
  logic top_bit;
  logic rx_ok;

  // rx_top_i[1] = bit 8, rx_top_i[0] = bit 7
  assign top_bit = nine_bit_i ? rx_top_i[1] : rx_top_i[0];
  assign rx_ok   = stat_i.rx_ready && (!addr_det_i || top_bit);

  assign src_o = (rx_ie_i    && (rx_ok || stat_i.overrun))
              || (idle_ie_i  && stat_i.tx_idle)
              || (empty_ie_i && stat_i.tx_empty)
              || (wake_en_i  && wake_edge_i);

  assign parity_en_eff_o = parity_en_i && !addr_det_i;
endmodule

// File: rtl/uart_irq_req.sv
module uart_irq_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic ack_i,
  output logic req_o
);
  logic src_q;
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      src_q <= src_i;
      if (src_i && !src_q) req_q <= 1'b1;
      else if (ack_i)      req_q <= 1'b0;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import uart_irq_pkg::*;
#(
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_empty_set_i,
  input  logic              tx_wr_i,
  input  logic              tx_idle_set_i,
  input  logic              tx_start_i,
  input  logic              rx_done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              overrun_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  input  logic              wake_edge_i,
  input  logic              nine_bit_i,
  input  logic              rx_ie_i,
  input  logic              idle_ie_i,
  input  logic              empty_ie_i,
  input  logic              wake_en_i,
  input  logic              addr_det_i,
  input  logic              parity_en_i,
  input  logic              mod_ie_i,
  input  logic              glob_ie_i,
  input  logic              ack_i,
  output logic              tx_empty_o,
  output logic              tx_idle_o,
  output logic              rx_ready_o,
  output logic              overrun_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              parity_en_eff_o,
  output logic              irq_flag_o,
  output logic              irq_o
);
  localparam int TOP9 = WORD_W - 1;
  localparam int TOP8 = WORD_W - 2;

  uart_stat_t        stat;
  logic [WORD_W-1:0] word;
  logic              src;

  uart_irq_status #(.WORD_W(WORD_W)) i_status (
    .clk_i, .rst_ni,
    .tx_empty_set_i, .tx_wr_i, .tx_idle_set_i, .tx_start_i,
    .rx_done_i, .rx_word_i, .overrun_i, .stat_rd_i, .data_rd_i,
    .stat_o(stat), .rx_data_o(word)
  );

  uart_irq_qual i_qual (
    .stat_i(stat), .rx_top_i({word[TOP9], word[TOP8]}),
    .nine_bit_i, .addr_det_i, .parity_en_i,
    .rx_ie_i, .idle_ie_i, .empty_ie_i, .wake_en_i, .wake_edge_i,
    .src_o(src), .parity_en_eff_o
  );

  uart_irq_req i_req (
    .clk_i, .rst_ni, .src_i(src), .ack_i, .req_o(irq_flag_o)
  );

  assign tx_empty_o = stat.tx_empty;
  assign tx_idle_o  = stat.tx_idle;
  assign rx_ready_o = stat.rx_ready;
  assign overrun_o  = stat.overrun;
  assign rx_data_o  = word;
  assign irq_o      = irq_flag_o && mod_ie_i && glob_ie_i;
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_done_i,
  input logic data_rd_i,
  input logic tx_wr_i,
  input logic tx_empty_set_i,
  input logic ack_i,
  input logic addr_det_i,
  input logic mod_ie_i,
  input logic glob_ie_i,
  input logic rx_ready_o,
  input logic overrun_o,
  input logic tx_empty_o,
  input logic parity_en_eff_o,
  input logic irq_flag_o,
  input logic irq_o
);
  a_r2_rx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> rx_ready_o);
  a_r3_ovr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !data_rd_i |=> overrun_o);
  a_r4_empty_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i && !tx_empty_set_i |=> !tx_empty_o);
  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_flag_o && !ack_i |=> irq_flag_o);
  a_r8_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mod_ie_i && glob_ie_i));
  a_r9_parity_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_det_i |-> !parity_en_eff_o);
  a_r10_ack_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && rx_ready_o && !data_rd_i |=> rx_ready_o);
endmodule

bind uart_irq_agg uart_irq_chk i_chk (.*);

// File: tb/test_uart_irq_agg.sv
module test_uart_irq_agg;
  localparam int W = 9;
  // vector: {nine_bit, addr_det, expect_req, word[8:0]}
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {3'b001, 9'h000}, {3'b010, 9'h07F}, {3'b011, 9'h080}, {3'b010, 9'h17F},
    {3'b110, 9'h0FF}, {3'b111, 9'h100}, {3'b101, 9'h0FF}, {3'b111, 9'h1FF}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tx_empty_set_i = 0, tx_wr_i = 0, tx_idle_set_i = 0, tx_start_i = 0;
  logic rx_done_i = 0, overrun_i = 0, stat_rd_i = 0, data_rd_i = 0, wake_edge_i = 0;
  logic [W-1:0] rx_word_i = '0;
  logic nine_bit_i = 0, rx_ie_i = 0, idle_ie_i = 0, empty_ie_i = 0, wake_en_i = 0;
  logic addr_det_i = 0, parity_en_i = 0, mod_ie_i = 0, glob_ie_i = 0, ack_i = 0;
  logic tx_empty_o, tx_idle_o, rx_ready_o, overrun_o, parity_en_eff_o, irq_flag_o, irq_o;
  logic [W-1:0] rx_data_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  uart_irq_agg #(.WORD_W(W)) i_uart_irq_agg (.*);

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic put_rx(logic [W-1:0] w);
    rx_word_i = w; rx_done_i = 1; cyc(); rx_done_i = 0;
  endtask

  task automatic clear_rx_req();
    data_rd_i = 1; ack_i = 1; cyc(); data_rd_i = 0; ack_i = 0; cyc();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(2); rst_ni = 1; cyc();
    chk("R1 tx_empty", tx_empty_o, 1);
    chk("R1 tx_idle", tx_idle_o, 1);
    chk("R1 rx_ready", rx_ready_o, 0);
    chk("R1 overrun", overrun_o, 0);
    chk("R1 irq_flag", irq_flag_o, 0);

    // R6 address qualification table
    rx_ie_i = 1;
    for (int i = 0; i < NV; i++) begin
      nine_bit_i = VEC[i][11]; addr_det_i = VEC[i][10];
      put_rx(VEC[i][8:0]);
      chk("R2 rx_data", rx_data_o, VEC[i][8:0]);
      cyc();
      chk($sformatf("R6 vec%0d", i), irq_flag_o, VEC[i][9]);
      clear_rx_req();
      chk("R2 rx cleared", rx_ready_o, 0);
    end
    addr_det_i = 0; nine_bit_i = 0;

    // R8 gating and R10 ack keeps status
    put_rx(9'h011); cyc();
    chk("R7 set", irq_flag_o, 1);
    mod_ie_i = 1; glob_ie_i = 0; #1;
    chk("R8 glob off", irq_o, 0);
    glob_ie_i = 1; #1;
    chk("R8 both on", irq_o, 1);
    mod_ie_i = 0; #1;
    chk("R8 mod off", irq_o, 0);
    cyc(3);
    chk("R7 hold", irq_flag_o, 1);
    ack_i = 1; cyc(); ack_i = 0;
    chk("R7 ack clears", irq_flag_o, 0);
    chk("R10 rx_ready kept", rx_ready_o, 1);
    data_rd_i = 1; cyc(); data_rd_i = 0; cyc();

    // R7 set and ack in same cycle
    put_rx(9'h022);
    ack_i = 1; cyc(); ack_i = 0;
    chk("R7 set wins ack", irq_flag_o, 1);
    ack_i = 1; cyc(); ack_i = 0;
    chk("R7 second ack", irq_flag_o, 0);
    clear_rx_req();
    rx_ie_i = 0;

    // R2 set priority
    rx_done_i = 1; data_rd_i = 1; cyc(); rx_done_i = 0; data_rd_i = 0;
    chk("R2 set wins", rx_ready_o, 1);
    data_rd_i = 1; cyc(); data_rd_i = 0;
    chk("R2 read clears", rx_ready_o, 0);

    // R3 overrun clear sequence
    overrun_i = 1; cyc(); overrun_i = 0;
    chk("R3 set", overrun_o, 1);
    data_rd_i = 1; cyc(); data_rd_i = 0;
    chk("R3 data read alone", overrun_o, 1);
    stat_rd_i = 1; cyc(); stat_rd_i = 0;
    chk("R3 status read alone", overrun_o, 1);
    data_rd_i = 1; cyc(); data_rd_i = 0;
    chk("R3 cleared", overrun_o, 0);

    // R4 transmit flags
    tx_wr_i = 1; tx_start_i = 1; cyc(); tx_wr_i = 0; tx_start_i = 0;
    chk("R4 empty clr", tx_empty_o, 0);
    chk("R4 idle clr", tx_idle_o, 0);
    tx_empty_set_i = 1; tx_wr_i = 1; tx_idle_set_i = 1; tx_start_i = 1; cyc();
    tx_empty_set_i = 0; tx_wr_i = 0; tx_idle_set_i = 0; tx_start_i = 0;
    chk("R4 empty set wins", tx_empty_o, 1);
    chk("R4 idle set wins", tx_idle_o, 1);

    // R5 enables
    wake_edge_i = 1; cyc(); wake_edge_i = 0; cyc(2);
    chk("R5 all disabled", irq_flag_o, 0);
    wake_en_i = 1; wake_edge_i = 1; cyc(); wake_edge_i = 0; cyc();
    chk("R5 wake", irq_flag_o, 1);
    wake_en_i = 0; ack_i = 1; cyc(); ack_i = 0; cyc();
    idle_ie_i = 1; cyc(2);
    chk("R5 idle", irq_flag_o, 1);
    ack_i = 1; cyc(); ack_i = 0; idle_ie_i = 0; cyc();
    empty_ie_i = 1; cyc(2);
    chk("R5 empty", irq_flag_o, 1);
    ack_i = 1; cyc(); ack_i = 0; empty_ie_i = 0; cyc();

    // R9 parity override
    parity_en_i = 1; addr_det_i = 0; #1;
    chk("R9 pass", parity_en_eff_o, 1);
    addr_det_i = 1; #1;
    chk("R9 forced off", parity_en_eff_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule